// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block drives one SPI master burst of 8-bit frames. A start pulse begins a burst. The burst runs for a programmed number of bytes. The first bytes of the burst are taken from an external transmit FIFO, up to a programmed transmit count. Every byte after that count goes out as zero, and the FIFO is not touched for those bytes. The byte received during each frame is written into an external receive FIFO, unless the discard control is set. A discarded byte is simply not stored, which suits transmit-only traffic.

Timing comes from an external divider. The divider delivers one `half_tick` strobe per half period of the serial clock. Clock polarity, clock phase and bit order are all selectable. There are four chip-select lines. They are driven either automatically around the burst, with a programmable active level, or directly by a manual level. Two sticky flags record the end of a burst and a received byte that was lost to a full receive FIFO. Each flag can raise the interrupt output when its enable bit is set. Configuration inputs must stay stable while the block is busy.

Top module: `spi_burst_engine`

## Requirements
- R1: `xfer_start` while idle makes `xfer_busy` 1 from the next cycle. `xfer_busy` stays 1 until the burst ends and then returns to 0 by itself. A start pulse while busy has no effect.
- R2: A burst transfers exactly `burst_len` bytes, which is 16 serial-clock edges per byte. A burst length of 0 ends with no clock edge.
- R3: Bytes with index below `tx_len` are popped from the transmit FIFO, one pop per byte. The remaining bytes are sent as 0x00 without a pop.
- R4: With `cfg_lsb_first`=0, bit 7 of each byte is shifted first. With `cfg_lsb_first`=1, bit 0 is shifted first. The same order applies to transmit and receive.
- R5: The serial clock rests at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading edge of each clock pulse. With `cfg_cpha`=1, data is sampled on the trailing edge.
- R6: Each received byte is pushed to the receive FIFO once its frame ends. When `cfg_drop_rx`=1, no byte is pushed.
- R7: If `rx_full` is 1 when a byte must be stored, that byte is dropped and overflow flag `sts_flags[1]` is set.
- R8: When a real byte is due and `tx_empty` is 1, the burst stalls with the serial clock at its idle level. It resumes once data arrives.
- R9: In automatic mode, `spi_cs[cfg_cs_sel]` is at `cfg_cs_pol` while busy. The line is asserted at least one half period before the first clock edge and is released one half-period strobe after the last edge. All other lines, and all lines while idle, are at `~cfg_cs_pol`.
- R10: With `cfg_cs_manual`=1, the selected line follows `cfg_cs_level` and the other lines stay at `~cfg_cs_pol`.
- R11: Done flag `sts_flags[0]` is set when a burst ends. Flags are cleared by writing 1 to the matching `sts_clr` bit, and 2'b11 clears both. `irq` is 1 exactly when some set flag has its `irq_en` bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xfer_start | input | 1 | Start pulse |
| xfer_busy | output | 1 | Burst in progress |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_lsb_first | input | 1 | Shift bit 0 first |
| cfg_drop_rx | input | 1 | Discard received bytes |
| cfg_cs_sel | input | 2 | Chip-select index |
| cfg_cs_manual | input | 1 | Manual chip-select mode |
| cfg_cs_level | input | 1 | Manual chip-select level |
| cfg_cs_pol | input | 1 | Active chip-select level |
| burst_len | input | 24 | Total bytes in burst |
| tx_len | input | 24 | Leading bytes from transmit FIFO |
| tx_data | input | 8 | Transmit FIFO head |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO push |
| rx_data | output | 8 | Receive FIFO write data |
| half_tick | input | 1 | Half-period strobe from divider |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |
| sts_clr | input | 2 | Write-one-to-clear for flags |
| irq_en | input | 2 | Interrupt enables |
| sts_flags | output | 2 | Bit 0 done, bit 1 overflow |
| irq | output | 1 | Interrupt |

## Verification
Bursts use random bytes under every combination of polarity, phase and bit order. The serial input is looped back from the output, so each received byte should equal the sent byte. The edges the bench observes are decoded in the expected order, which separates the two bit orders and exposes a phase mixup as misaligned bits. Transmit counts below, equal to and above the burst length tell real bytes from zero fill and show whether extra pops occur. Directed cases cover a zero-length burst, a stalled empty FIFO, a full receive FIFO, discard mode, manual chip select and flag clearing.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE,
        ST_TRAIL
    } seq_state_e;

    localparam int STS_DONE = 0;
    localparam int STS_OVF  = 1;
    localparam int STS_W    = 2;
endpackage

// File: rtl/spi_burst_fsm.sv
module spi_burst_fsm
    import spi_burst_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          half_tick,
    input  logic          cpha,
    input  logic          cpol,
    input  logic          lsb_first,
    input  logic          drop_rx,
    input  logic [CW-1:0] burst_len,
    input  logic [CW-1:0] tx_len,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_empty,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done_pulse,
    output logic          ovf_pulse
);
    localparam int EW = $clog2(2 * DW);
    localparam int BW = $clog2(DW);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] idx;
        logic [EW-1:0] edg;
        logic          ph;
        logic [DW-1:0] txb;
        logic [DW-1:0] rxb;
        logic          out;
    } seq_t;

    seq_t q, d;

    // bit k of a frame in shift order
    function automatic logic pick(input logic [DW-1:0] b, input logic [BW-1:0] k,
                                  input logic lsb);
        return lsb ? b[k] : b[BW'(DW - 1) - k];
    endfunction

    function automatic logic [DW-1:0] place(input logic [DW-1:0] b, input logic [BW-1:0] k,
                                            input logic lsb, input logic v);
        logic [DW-1:0] r;
        r = b;
        if (lsb) r[k] = v;
        else     r[BW'(DW - 1) - k] = v;
        return r;
    endfunction

    logic          real_byte;
    logic          lead_e;
    logic [BW-1:0] k;
    logic [DW-1:0] fetched;
    logic [CW-1:0] idx_inc;

    always_comb begin
        d          = q;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        done_pulse = 1'b0;
        ovf_pulse  = 1'b0;
        real_byte  = q.idx < tx_len;
        lead_e     = ~q.edg[0];
        k          = BW'(q.edg >> 1);
        fetched    = real_byte ? tx_data : '0;
        idx_inc    = q.idx + CW'(1);
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_LEAD;
                    d.idx = '0;
                    d.ph  = 1'b0;
                end
            end
            ST_LEAD: begin
                if (half_tick) d.st = (q.idx < burst_len) ? ST_LOAD : ST_TRAIL;
            end
            ST_LOAD: begin
                if (!(real_byte && tx_empty)) begin
                    tx_pop = real_byte;
                    d.txb  = fetched;
                    d.rxb  = '0;
                    d.edg  = '0;
                    if (!cpha) d.out = pick(fetched, '0, lsb_first);
                    d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (half_tick) begin
                    d.ph  = ~q.ph;
                    d.edg = q.edg + EW'(1);
                    if (lead_e != cpha) d.rxb = place(q.rxb, k, lsb_first, miso);
                    if (!cpha && !lead_e && q.edg != LAST_EDGE)
                        d.out = pick(q.txb, k + BW'(1), lsb_first);
                    if (cpha && lead_e) d.out = pick(q.txb, k, lsb_first);
                    if (q.edg == LAST_EDGE) d.st = ST_STORE;
                end
            end
            ST_STORE: begin
                if (!drop_rx) begin
                    if (rx_full) ovf_pulse = 1'b1;
                    else         rx_push   = 1'b1;
                end
                d.idx = idx_inc;
                d.st  = (idx_inc < burst_len) ? ST_LOAD : ST_TRAIL;
            end
            ST_TRAIL: begin
                if (half_tick) begin
                    d.st       = ST_IDLE;
                    done_pulse = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= seq_t'('0);
        else        q <= d;
    end

    assign rx_data = q.rxb;
    assign sclk    = cpol ^ q.ph;
    assign mosi    = q.out;
    assign busy    = (q.st != ST_IDLE);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    p_push_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !drop_rx);
    p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    p_pop_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    p_stall_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD) |-> (sclk == cpol));
    p_idle_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int NCS = 4,
    parameter int SW  = $clog2(NCS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic [SW-1:0]  cs_sel,
    input  logic           manual,
    input  logic           level,
    input  logic           pol,
    output logic [NCS-1:0] cs_o
);
    logic [NCS-1:0] cs_d;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        always_comb begin
            if (cs_sel == SW'(i)) cs_d[i] = manual ? level : (busy ? pol : ~pol);
            else                  cs_d[i] = ~pol;
        end
    end

    assign cs_o = cs_d;

    p_single_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o ^ {NCS{~pol}}));
    p_auto_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && busy) |-> (cs_o[cs_sel] == pol));
    p_manual_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        manual |-> (cs_o[cs_sel] == level));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] ie,
    output logic [W-1:0] sts,
    output logic         irq
);
    logic [W-1:0] sts_d, sts_q;

    always_comb sts_d = (sts_q & ~clr) | set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts = sts_q;
    assign irq = |(sts_q & ie);

    for (genvar i = 0; i < W; i++) begin : g_chk
        p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !clr[i]) |=> sts_q[i]);
        p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !sts_q[i]);
    end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int DW  = 8,
    parameter int CW  = 24,
    parameter int NCS = 4,
    localparam int SW = $clog2(NCS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xfer_start,
    output logic           xfer_busy,
    input  logic           cfg_cpha,
    input  logic           cfg_cpol,
    input  logic           cfg_lsb_first,
    input  logic           cfg_drop_rx,
    input  logic [SW-1:0]  cfg_cs_sel,
    input  logic           cfg_cs_manual,
    input  logic           cfg_cs_level,
    input  logic           cfg_cs_pol,
    input  logic [CW-1:0]  burst_len,
    input  logic [CW-1:0]  tx_len,
    input  logic [DW-1:0]  tx_data,
    input  logic           tx_empty,
    output logic           tx_pop,
    input  logic           rx_full,
    output logic           rx_push,
    output logic [DW-1:0]  rx_data,
    input  logic           half_tick,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs,
    input  logic [STS_W-1:0] sts_clr,
    input  logic [STS_W-1:0] irq_en,
    output logic [STS_W-1:0] sts_flags,
    output logic           irq
);
    logic done_pulse, ovf_pulse;
    logic [STS_W-1:0] sts_set;

    spi_burst_fsm #(.DW(DW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .half_tick(half_tick),
        .cpha(cfg_cpha), .cpol(cfg_cpol), .lsb_first(cfg_lsb_first),
        .drop_rx(cfg_drop_rx), .burst_len(burst_len), .tx_len(tx_len),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(xfer_busy),
        .done_pulse(done_pulse), .ovf_pulse(ovf_pulse)
    );

    spi_cs_drive #(.NCS(NCS)) u_cs (
        .clk(clk), .rst_n(rst_n), .busy(xfer_busy), .cs_sel(cfg_cs_sel),
        .manual(cfg_cs_manual), .level(cfg_cs_level), .pol(cfg_cs_pol),
        .cs_o(spi_cs)
    );

    always_comb begin
        sts_set           = '0;
        sts_set[STS_DONE] = done_pulse;
        sts_set[STS_OVF]  = ovf_pulse;
    end

    spi_irq_status #(.W(STS_W)) u_sts (
        .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr), .ie(irq_en),
        .sts(sts_flags), .irq(irq)
    );

    p_done_on_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> sts_flags[STS_DONE]);
endmodule

// File: tb/tb_spi_burst_engine.sv
module tb_spi_burst_engine;
    localparam int DIV = 3;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic xfer_start = 0, xfer_busy;
    logic cfg_cpha = 0, cfg_cpol = 0, cfg_lsb_first = 0, cfg_drop_rx = 0;
    logic [1:0] cfg_cs_sel = 0;
    logic cfg_cs_manual = 0, cfg_cs_level = 0, cfg_cs_pol = 0;
    logic [23:0] burst_len = 0, tx_len = 0;
    logic [7:0] tx_data, rx_data;
    logic tx_empty, tx_pop, rx_full = 0, rx_push;
    logic half_tick = 0;
    logic spi_sclk, spi_mosi, spi_miso;
    logic [3:0] spi_cs;
    logic [1:0] sts_clr = 0, irq_en = 0, sts_flags;
    logic irq;

    int checks = 0, errors = 0;
    logic [7:0] txq [0:63];
    logic [7:0] rxq [0:63];
    logic bits [0:511];
    int ptr = 0, avail = 64, pop_cnt = 0, rx_cnt = 0, edge_cnt = 0, nbits = 0;
    int cs_err = 0, cyc = 0, rise_cyc = 0, first_gap = -1;
    logic prev_sclk = 0, prev_busy = 0, pop_flag = 0;
    int div_cnt = 0;

    assign tx_data  = txq[ptr[5:0]];
    assign tx_empty = (ptr >= avail);
    assign spi_miso = spi_mosi;

    spi_burst_engine dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
        .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
        .cfg_drop_rx(cfg_drop_rx), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_manual(cfg_cs_manual),
        .cfg_cs_level(cfg_cs_level), .cfg_cs_pol(cfg_cs_pol), .burst_len(burst_len),
        .tx_len(tx_len), .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data), .half_tick(half_tick),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
        .sts_clr(sts_clr), .irq_en(irq_en), .sts_flags(sts_flags), .irq(irq)
    );

    always @(posedge clk) begin
        if (div_cnt == DIV - 1) begin div_cnt <= 0; half_tick <= 1; end
        else begin div_cnt <= div_cnt + 1; half_tick <= 0; end
        if (pop_flag) ptr <= ptr + 1;
    end

    // monitor: sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        pop_flag = tx_pop;
        if (tx_pop) pop_cnt = pop_cnt + 1;
        if (rx_push) begin rxq[rx_cnt[5:0]] = rx_data; rx_cnt = rx_cnt + 1; end
        if (xfer_busy && !prev_busy) rise_cyc = cyc;
        if (xfer_busy && spi_sclk !== prev_sclk) begin
            if (edge_cnt == 0) first_gap = cyc - rise_cyc;
            edge_cnt = edge_cnt + 1;
            if ((prev_sclk == cfg_cpol) != cfg_cpha) begin
                bits[nbits[8:0]] = spi_mosi;
                nbits = nbits + 1;
            end
        end
        if (!cfg_cs_manual && rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (spi_cs[i] !== ((xfer_busy && i == int'(cfg_cs_sel)) ? cfg_cs_pol : ~cfg_cs_pol))
                    cs_err = cs_err + 1;
            end
        end
        prev_sclk = spi_sclk;
        prev_busy = xfer_busy;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int j, input int tl);
        return (j < tl) ? txq[j] : 8'h00;
    endfunction

    task automatic run_burst(input bit pha, input bit pol, input bit lsb, input bit drop,
                             input int blen, input int tlen, input int sel,
                             input bit stall, input bit restart);
        int mism, rx_exp, rx_bad, pops_exp, guard;
        cfg_cpha = pha; cfg_cpol = pol; cfg_lsb_first = lsb; cfg_drop_rx = drop;
        cfg_cs_sel = sel[1:0]; cfg_cs_manual = 0;
        burst_len = blen[23:0]; tx_len = tlen[23:0];
        for (int i = 0; i < 64; i++) txq[i] = 8'($urandom);
        @(negedge clk); @(negedge clk);
        ptr = 0; avail = stall ? 0 : 64;
        pop_cnt = 0; rx_cnt = 0; edge_cnt = 0; nbits = 0; cs_err = 0; first_gap = -1;
        sts_clr = 2'b11; @(negedge clk); sts_clr = 2'b00;
        xfer_start = 1; @(negedge clk); xfer_start = 0;
        chk(xfer_busy == 1, "R1 busy after start", int'(xfer_busy), 1);
        if (stall) begin
            repeat (40) @(negedge clk);
            chk(edge_cnt == 0 && spi_sclk == pol && xfer_busy, "R8 stall", edge_cnt, 0);
            avail = 64;
        end
        if (restart) begin
            repeat (20) @(negedge clk);
            xfer_start = 1; @(negedge clk); xfer_start = 0;
        end
        guard = 0;
        while (xfer_busy && guard < 5000) begin @(negedge clk); guard++; end
        chk(edge_cnt == 16 * blen, "R2 edge count", edge_cnt, 16 * blen);
        pops_exp = (tlen < blen) ? tlen : blen;
        chk(pop_cnt == pops_exp, "R3 pops", pop_cnt, pops_exp);
        mism = (nbits == 8 * blen) ? 0 : 1000;
        for (int j = 0; j < blen && mism == 0; j++)
            for (int b = 0; b < 8; b++)
                if (bits[j * 8 + b] !== (lsb ? exp_byte(j, tlen)[b] : exp_byte(j, tlen)[7 - b]))
                    mism++;
        chk(mism == 0, "R4 R5 bit order and phase", mism, 0);
        rx_exp = (drop || rx_full) ? 0 : blen;
        chk(rx_cnt == rx_exp, "R6 push count", rx_cnt, rx_exp);
        rx_bad = 0;
        for (int j = 0; j < rx_cnt && j < 64; j++)
            if (rxq[j] !== exp_byte(j, tlen)) rx_bad++;
        chk(rx_bad == 0, "R6 rx data", rx_bad, 0);
        chk(sts_flags[1] == (!drop && rx_full && blen > 0), "R7 overflow flag",
            int'(sts_flags[1]), int'(!drop && rx_full && blen > 0));
        chk(cs_err == 0, "R9 chip select", cs_err, 0);
        if (blen > 0)
            chk(first_gap >= DIV, "R9 lead time", first_gap, DIV);
        chk(sts_flags[0] == 1, "R11 done flag", int'(sts_flags[0]), 1);
        repeat (20) @(negedge clk);
        chk(xfer_busy == 0 && spi_sclk == pol, "R1 R5 idle after burst", int'(xfer_busy), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(xfer_busy == 0 && sts_flags == 0 && irq == 0 && spi_cs == 4'hF,
            "R1 reset state", int'(spi_cs), 15);
        rst_n = 1;
        @(negedge clk);

        // directed: all four modes, both orders
        run_burst(0, 0, 0, 0, 3, 3, 0, 0, 0);
        run_burst(1, 1, 1, 0, 2, 2, 3, 0, 0);
        run_burst(0, 1, 1, 0, 4, 1, 1, 0, 1);   // zero fill, restart ignored (R1)
        run_burst(1, 0, 0, 1, 3, 5, 2, 0, 0);   // discard, tx count above length
        run_burst(0, 0, 0, 0, 0, 0, 0, 0, 0);   // zero-length (R2)
        run_burst(1, 0, 0, 0, 2, 2, 1, 1, 0);   // stall (R8)
        rx_full = 1;
        run_burst(0, 0, 1, 0, 2, 2, 0, 0, 0);   // overflow (R7)
        run_burst(0, 0, 1, 1, 2, 2, 0, 0, 0);   // discard with full: no overflow
        rx_full = 0;

        for (int n = 0; n < 12; n++) begin
            int bl;
            bl = 1 + int'($urandom % 5);
            cfg_cs_pol = 1'($urandom);
            run_burst(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                      bl, int'($urandom % (bl + 2)), int'($urandom % 4), 0, 0);
        end
        cfg_cs_pol = 0;

        // R11: irq gating and clearing
        irq_en = 2'b00; @(negedge clk);
        chk(irq == 0, "R11 irq masked", int'(irq), 0);
        irq_en = 2'b01; @(negedge clk);
        chk(irq == 1, "R11 irq enabled", int'(irq), 1);
        sts_clr = 2'b11; @(negedge clk); sts_clr = 2'b00;
        chk(sts_flags == 0 && irq == 0, "R11 clear all", int'(sts_flags), 0);
        irq_en = 2'b00;

        // R10: manual chip select
        cfg_cs_pol = 0; cfg_cs_sel = 2; cfg_cs_manual = 1; cfg_cs_level = 1;
        @(negedge clk);
        chk(spi_cs == 4'b1111, "R10 manual high", int'(spi_cs), 15);
        cfg_cs_level = 0; @(negedge clk);
        chk(spi_cs == 4'b1011, "R10 manual low", int'(spi_cs), 11);
        cfg_cs_pol = 1; cfg_cs_level = 1; @(negedge clk);
        chk(spi_cs == 4'b0100, "R10 manual other lines", int'(spi_cs), 4);
        cfg_cs_manual = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule